// File: doc/BRIEF.md
# Interrupt Source Gateway Array

This block keeps the state of a parameterised set of external interrupt sources. Sources are numbered from 1; slot 0 has no state and always reads zero. Each source holds a trigger mode, a pending bit, an enable bit and a sampled copy of its input wire. Every clock the block samples each raw wire, which is assumed to be already synchronous to `clk_i`. It then applies the source's trigger mode (off, detached, rising edge, falling edge, active-high level or active-low level) to decide whether pending is set.

Software reaches the array through two ports. A configuration port writes and reads each source's mode. A command port sets or clears pending and enable for one source at a time. A message generator downstream watches the `pending_o` and `enabled_o` vectors. It hands a source off by pulsing that source's bit on `ack_i`, which clears its pending bit. A rectified input vector shows each sampled wire after the mode's polarity has been applied.

Top module: `src_gateway_array`

## Requirements
- R1: Index 0, and any index at or above `N_SRC`, is invalid. Configuration reads of an invalid index return 0. Configuration writes and commands to an invalid index change nothing. Bit 0 of every output vector is always 0.
- R2: A configuration write with bit 10 set stores 0. Any other configuration write stores only bits 2:0 (the mode). A configuration read returns the stored mode in bits 2:0, with all other bits 0.
- R3: In mode 4 (rising edge), pending is set at the clock edge where the raw input is 1 and the sampled bit is 0. The sampled bit follows the raw input at every clock edge.
- R4: In mode 5 (falling edge), pending is set at the clock edge where the raw input is 0 and the sampled bit is 1.
- R5: In mode 6 (level high), pending is set at every edge where the raw input is 1. In mode 7 (level low), pending is set at every edge where the raw input is 0. In both level modes, pending stays set after the input deasserts.
- R6: In the level modes, a software clear-pending command is ignored. A software set-pending command takes effect only while the rectified input is 1.
- R7: In mode 0 (off), and in the unused modes 2 and 3, the wire never sets pending and software set or clear of pending has no effect.
- R8: `rect_o[i]` equals the sampled bit XOR an inversion flag. The flag is 1 in modes 5 and 7 and 0 in modes 4 and 6. `rect_o[i]` is 0 in modes 0, 1, 2 and 3.
- R9: In the edge modes and in mode 1 (detached), software set-pending and clear-pending commands act at the next edge. In mode 1 the wire is ignored and the sampled bit is held at 0.
- R10: Command 3 sets and command 4 clears the enable bit of the addressed source. Command 1 is set-pending, command 2 is clear-pending, and command 0 does nothing.
- R11: `ack_i[i]` clears pending at the next edge. If a trigger or an accepted set occurs at the same edge, pending stays set.
- R12: After reset, all modes, pending bits, enable bits and sampled bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raw_i | input | N_SRC | Raw source wires, already synchronous |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_widx_i | input | IDX_W | Configuration write index |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_ridx_i | input | IDX_W | Configuration read index |
| cfg_rdata_o | output | 32 | Configuration read data (combinational) |
| sw_op_i | input | 3 | Software command, encoded as in R10 |
| sw_idx_i | input | IDX_W | Software command target index |
| ack_i | input | N_SRC | Per-source clear-pending strobes |
| pending_o | output | N_SRC | Pending bits |
| enabled_o | output | N_SRC | Enable bits |
| rect_o | output | N_SRC | Rectified sampled inputs |

## Verification
The hardest cases to reach are the level-mode software rules. Their effect is hidden whenever the wire itself is asserting pending. To expose them, the stimulus first sets pending through the wire and then drops the wire, so pending holds only by memory. A clear command then shows that it is ignored. Next an ack removes the pending bit, and a set command is issued while the rectified input is low, which shows the set is refused. A similar case is the ack that lands on a live level input, which checks that the set takes precedence over the clear at the same edge.

// File: rtl/gw_pkg.sv
package gw_pkg;
  localparam int MODE_W    = 3;
  localparam int CFG_W     = 32;
  localparam int DELEG_BIT = 10;

  localparam logic [MODE_W-1:0] MODE_OFF    = 3'd0;
  localparam logic [MODE_W-1:0] MODE_DETACH = 3'd1;
  localparam logic [MODE_W-1:0] MODE_RISE   = 3'd4;
  localparam logic [MODE_W-1:0] MODE_FALL   = 3'd5;
  localparam logic [MODE_W-1:0] MODE_HIGH   = 3'd6;
  localparam logic [MODE_W-1:0] MODE_LOW    = 3'd7;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SET_IP = 3'd1,
    OP_CLR_IP = 3'd2,
    OP_SET_IE = 3'd3,
    OP_CLR_IE = 3'd4
  } sw_op_e;

  function automatic logic mode_is_level(logic [MODE_W-1:0] m);
    return (m == MODE_HIGH) || (m == MODE_LOW);
  endfunction

  function automatic logic mode_is_edge(logic [MODE_W-1:0] m);
    return (m == MODE_RISE) || (m == MODE_FALL);
  endfunction

  function automatic logic mode_inverts(logic [MODE_W-1:0] m);
    return (m == MODE_FALL) || (m == MODE_LOW);
  endfunction
endpackage

// File: rtl/gw_cfg_regs.sv
module gw_cfg_regs
  import gw_pkg::*;
#(
  parameter int N_SRC = 12,
  parameter int IDX_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        widx_i,
  input  logic [CFG_W-1:0]        wdata_i,
  input  logic [IDX_W-1:0]        ridx_i,
  output logic [CFG_W-1:0]        rdata_o,
  output logic [N_SRC*MODE_W-1:0] mode_flat_o
);
  logic [MODE_W-1:0] wmode;

  assign wmode = wdata_i[DELEG_BIT] ? MODE_OFF : wdata_i[MODE_W-1:0];
  assign mode_flat_o[MODE_W-1:0] = MODE_OFF;

  for (genvar i = 1; i < N_SRC; i++) begin : g_cfg
    logic [MODE_W-1:0] mode_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mode_q <= MODE_OFF;
      else if (we_i && widx_i == IDX_W'(i))      mode_q <= wmode;
    end
    assign mode_flat_o[i*MODE_W +: MODE_W] = mode_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 1; k < N_SRC; k++) begin
      if (ridx_i == IDX_W'(k)) rdata_o[MODE_W-1:0] = mode_flat_o[k*MODE_W +: MODE_W];
    end
  end
endmodule

// File: rtl/gw_sw_decode.sv
module gw_sw_decode
  import gw_pkg::*;
#(
  parameter int N_SRC = 12,
  parameter int IDX_W = 4
) (
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N_SRC-1:0] set_ip_o,
  output logic [N_SRC-1:0] clr_ip_o,
  output logic [N_SRC-1:0] set_ie_o,
  output logic [N_SRC-1:0] clr_ie_o
);
  sw_op_e op;
  assign op = sw_op_e'(op_i);

  assign set_ip_o[0] = 1'b0;
  assign clr_ip_o[0] = 1'b0;
  assign set_ie_o[0] = 1'b0;
  assign clr_ie_o[0] = 1'b0;

  for (genvar i = 1; i < N_SRC; i++) begin : g_dec
    logic hit;
    assign hit         = (idx_i == IDX_W'(i));
    assign set_ip_o[i] = hit && (op == OP_SET_IP);
    assign clr_ip_o[i] = hit && (op == OP_CLR_IP);
    assign set_ie_o[i] = hit && (op == OP_SET_IE);
    assign clr_ie_o[i] = hit && (op == OP_CLR_IE);
  end
endmodule

// File: rtl/gw_src_cell.sv
module gw_src_cell
  import gw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              raw_i,
  input  logic              set_ip_i,
  input  logic              clr_ip_i,
  input  logic              set_ie_i,
  input  logic              clr_ie_i,
  input  logic              ack_i,
  output logic              pend_o,
  output logic              en_o,
  output logic              samp_o,
  output logic              rect_o
);
  logic pend_q, en_q, samp_q;
  logic lvl, edg, det, inv;
  logic trig, set_ok, clr_ok;

  assign lvl = mode_is_level(mode_i);
  assign edg = mode_is_edge(mode_i);
  assign det = (mode_i == MODE_DETACH);
  assign inv = mode_inverts(mode_i);

  assign rect_o = (lvl || edg) ? (samp_q ^ inv) : 1'b0;

  always_comb begin
    unique case (mode_i)
      MODE_RISE: trig = raw_i & ~samp_q;
      MODE_FALL: trig = ~raw_i & samp_q;
      MODE_HIGH: trig = raw_i;
      MODE_LOW:  trig = ~raw_i;
      default:   trig = 1'b0;
    endcase
  end

  // level set gated by the currently sampled rectified level
  assign set_ok = set_ip_i && (det || edg || (lvl && rect_o));
  assign clr_ok = clr_ip_i && (det || edg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~(ack_i | clr_ok)) | trig | set_ok;
      en_q   <= (en_q | set_ie_i) & ~clr_ie_i;
      samp_q <= det ? 1'b0 : raw_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign samp_o = samp_q;
endmodule

// File: rtl/src_gateway_array.sv
module src_gateway_array
  import gw_pkg::*;
#(
  parameter int N_SRC = 12,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] raw_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_widx_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic [IDX_W-1:0] cfg_ridx_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic [2:0]       sw_op_i,
  input  logic [IDX_W-1:0] sw_idx_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] pending_o,
  output logic [N_SRC-1:0] enabled_o,
  output logic [N_SRC-1:0] rect_o
);
  logic [N_SRC*MODE_W-1:0] mode_flat;
  logic [N_SRC-1:0] set_ip, clr_ip, set_ie, clr_ie;
  logic [N_SRC-1:0] samp_vec;

  gw_cfg_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .widx_i      (cfg_widx_i),
    .wdata_i     (cfg_wdata_i),
    .ridx_i      (cfg_ridx_i),
    .rdata_o     (cfg_rdata_o),
    .mode_flat_o (mode_flat)
  );

  gw_sw_decode #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_dec (
    .op_i     (sw_op_i),
    .idx_i    (sw_idx_i),
    .set_ip_o (set_ip),
    .clr_ip_o (clr_ip),
    .set_ie_o (set_ie),
    .clr_ie_o (clr_ie)
  );

  assign pending_o[0] = 1'b0;
  assign enabled_o[0] = 1'b0;
  assign rect_o[0]    = 1'b0;
  assign samp_vec[0]  = 1'b0;

  for (genvar i = 1; i < N_SRC; i++) begin : g_src
    gw_src_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode_flat[i*MODE_W +: MODE_W]),
      .raw_i    (raw_i[i]),
      .set_ip_i (set_ip[i]),
      .clr_ip_i (clr_ip[i]),
      .set_ie_i (set_ie[i]),
      .clr_ie_i (clr_ie[i]),
      .ack_i    (ack_i[i]),
      .pend_o   (pending_o[i]),
      .en_o     (enabled_o[i]),
      .samp_o   (samp_vec[i]),
      .rect_o   (rect_o[i])
    );
  end
endmodule

// File: rtl/gw_checker.sv
module gw_checker
  import gw_pkg::*;
#(
  parameter int N_SRC = 12,
  parameter int IDX_W = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC-1:0]        raw_i,
  input logic [2:0]              sw_op_i,
  input logic [IDX_W-1:0]        sw_idx_i,
  input logic [N_SRC-1:0]        ack_i,
  input logic [N_SRC-1:0]        pending_o,
  input logic [N_SRC-1:0]        enabled_o,
  input logic [N_SRC-1:0]        rect_o,
  input logic [N_SRC*MODE_W-1:0] mode_flat_i,
  input logic [N_SRC-1:0]        samp_i
);
  // R1
  slot0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_o[0] && !enabled_o[0] && !rect_o[0]);

  for (genvar i = 1; i < N_SRC; i++) begin : g_chk
    logic [MODE_W-1:0] m;
    assign m = mode_flat_i[i*MODE_W +: MODE_W];

    // R3
    rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == MODE_RISE && raw_i[i] && !samp_i[i]) |=> pending_o[i]);

    // R5
    level_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == MODE_HIGH && raw_i[i]) |=> pending_o[i]);

    // R6
    level_noclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_is_level(m) && pending_o[i] && !ack_i[i] &&
       sw_op_i == 3'd2 && sw_idx_i == IDX_W'(i)) |=> pending_o[i]);

    // R7
    off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == MODE_OFF && !pending_o[i]) |=> !pending_o[i]);

    // R8
    rect_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == MODE_OFF || m == MODE_DETACH) |-> !rect_o[i]);

    // R10
    ie_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_op_i == 3'd4 && sw_idx_i == IDX_W'(i)) |=> !enabled_o[i]);
  end
endmodule

bind src_gateway_array gw_checker #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .raw_i       (raw_i),
  .sw_op_i     (sw_op_i),
  .sw_idx_i    (sw_idx_i),
  .ack_i       (ack_i),
  .pending_o   (pending_o),
  .enabled_o   (enabled_o),
  .rect_o      (rect_o),
  .mode_flat_i (mode_flat),
  .samp_i      (samp_vec)
);

// File: tb/src_gateway_array_tb.sv
`timescale 1ns/1ps
module src_gateway_array_tb;
  localparam int N = 12;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  raw = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_widx = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [IW-1:0] cfg_ridx = '0;
  logic [31:0]   cfg_rdata;
  logic [2:0]    sw_op = '0;
  logic [IW-1:0] sw_idx = '0;
  logic [N-1:0]  ack = '0;
  logic [N-1:0]  pend, en, rect;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  src_gateway_array #(.N_SRC(N), .IDX_W(IW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .raw_i(raw),
    .cfg_we_i(cfg_we), .cfg_widx_i(cfg_widx), .cfg_wdata_i(cfg_wdata),
    .cfg_ridx_i(cfg_ridx), .cfg_rdata_o(cfg_rdata),
    .sw_op_i(sw_op), .sw_idx_i(sw_idx), .ack_i(ack),
    .pending_o(pend), .enabled_o(en), .rect_o(rect)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_wr(int idx, logic [31:0] d);
    cfg_we = 1'b1; cfg_widx = IW'(idx); cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd_chk(string req, int idx, logic [31:0] exp);
    cfg_ridx = IW'(idx);
    #0.5;
    check(req, cfg_rdata, exp);
  endtask

  task automatic sw(int op, int idx);
    sw_op = 3'(op); sw_idx = IW'(idx);
    tick();
    sw_op = 3'd0;
  endtask

  task automatic ack_one(int idx);
    ack[idx] = 1'b1;
    tick();
    ack[idx] = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 pending", 32'(pend), 0);
    check("R12 enabled", 32'(en), 0);
    check("R12 rect", 32'(rect), 0);
    cfg_rd_chk("R12 cfg", 3, 0);
  endtask

  task automatic t_cfg();
    cfg_wr(8, 32'h0000_03F6);
    cfg_rd_chk("R2 mode kept", 8, 32'h6);
    cfg_wr(8, 32'h0000_0406);
    cfg_rd_chk("R2 delegate zero", 8, 32'h0);
  endtask

  task automatic t_invalid();
    cfg_wr(0, 32'h6);
    cfg_rd_chk("R1 idx0 cfg", 0, 0);
    cfg_wr(13, 32'h6);
    cfg_rd_chk("R1 idx13 cfg", 13, 0);
    sw(3, 0);
    sw(3, 13);
    sw(1, 14);
    check("R1 invalid cmds", 32'({en, pend}), 0);
  endtask

  task automatic t_rise();
    cfg_wr(1, 32'h4);
    raw[1] = 1'b1; tick();
    check("R3 rise sets", 32'(pend[1]), 1);
    ack_one(1);
    check("R11 ack clears", 32'(pend[1]), 0);
    tick();
    check("R3 held high no reset", 32'(pend[1]), 0);
    raw[1] = 1'b0; tick();
    raw[1] = 1'b1; tick();
    check("R3 second rise", 32'(pend[1]), 1);
    ack_one(1);
  endtask

  task automatic t_fall();
    cfg_wr(2, 32'h5);
    raw[2] = 1'b1; tick();
    check("R4 rise ignored", 32'(pend[2]), 0);
    check("R8 fall rect high", 32'(rect[2]), 0);
    raw[2] = 1'b0; tick();
    check("R4 fall sets", 32'(pend[2]), 1);
    check("R8 fall rect low", 32'(rect[2]), 1);
    ack_one(2);
  endtask

  task automatic t_level();
    cfg_wr(3, 32'h6);
    raw[3] = 1'b1; tick();
    check("R5 high sets", 32'(pend[3]), 1);
    check("R8 high rect", 32'(rect[3]), 1);
    ack_one(3);
    check("R11 level wins over ack", 32'(pend[3]), 1);
    raw[3] = 1'b0; tick();
    check("R5 held after drop", 32'(pend[3]), 1);
    sw(2, 3);
    check("R6 clr ignored", 32'(pend[3]), 1);
    ack_one(3);
    check("R11 ack level low", 32'(pend[3]), 0);
    sw(1, 3);
    check("R6 set refused", 32'(pend[3]), 0);
    cfg_wr(4, 32'h7);
    tick();
    check("R5 low sets", 32'(pend[4]), 1);
    check("R8 low rect", 32'(rect[4]), 1);
    raw[4] = 1'b1; ack_one(4);
    check("R5 low cleared", 32'(pend[4]), 0);
    check("R8 low rect off", 32'(rect[4]), 0);
  endtask

  task automatic t_off();
    raw[5] = 1'b1; tick();
    raw[5] = 1'b0; tick();
    check("R7 off wire", 32'(pend[5]), 0);
    sw(1, 5);
    check("R7 off sw set", 32'(pend[5]), 0);
    cfg_wr(5, 32'h2);
    raw[5] = 1'b1; tick();
    check("R7 mode2 wire", 32'(pend[5]), 0);
    check("R8 mode2 rect", 32'(rect[5]), 0);
  endtask

  task automatic t_sw_edge_det();
    sw(1, 1);
    check("R9 edge sw set", 32'(pend[1]), 1);
    sw(2, 1);
    check("R9 edge sw clr", 32'(pend[1]), 0);
    cfg_wr(6, 32'h1);
    raw[6] = 1'b1; tick();
    check("R9 detached wire", 32'(pend[6]), 0);
    check("R8 detached rect", 32'(rect[6]), 0);
    sw(1, 6);
    check("R9 detached set", 32'(pend[6]), 1);
    sw(2, 6);
    check("R9 detached clr", 32'(pend[6]), 0);
  endtask

  task automatic t_enable();
    sw(3, 1);
    sw(3, 7);
    check("R10 set ie", 32'(en), 32'h082);
    sw(4, 1);
    check("R10 clr ie", 32'(en), 32'h080);
    sw(0, 7);
    check("R10 no-op", 32'(en), 32'h080);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_cfg();
    t_invalid();
    t_rise();
    t_fall();
    t_level();
    t_off();
    t_sw_edge_det();
    t_enable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule